// File: doc/BRIEF.md
# Writeback Frame Capture Sequencer

This block steps through the capture of one output frame into memory. Software programs a destination base pointer, a line pitch and the frame size through a small register port, then sets a start bit in the control word. The block then walks the frame one line at a time. For every line it raises a write request on a request/acknowledge memory port, carrying the line address and the line width, and waits for the acknowledge. Each acknowledge means that the line is committed. The block then counts it and moves to the next line.

When the frame ends, either normally or by abort, the block drops back to idle. If the interrupt-enable bit is set, it raises a level interrupt at that point. Software acknowledges the interrupt by clearing that bit. A power-down bit in the same word keeps any frame from starting. The upper bits of the control word always return a fixed identification pattern.

Top module: `frame_capture_seq`

## Requirements
- R1: After reset the base, pitch, size and progress registers read 0, the control word reads 0x5440_0000, and `irq` and `memReq` are low.
- R2: Control word bits 31:24 always read 0x54 and bits 23:22 always read 01, whatever is written to them. The start bit (bit 0) and the abort bit (bit 14) always read 0.
- R3: The base register (offset 0x00) ignores its two low bits and the pitch register (offset 0x04) ignores its four low bits; both read those bits as 0. Writing a height above 4088 to the size register (offset 0x08: height in 31:16, width in 15:0) stores 4088.
- R4: A write to the control word (offset 0x0C) with bit 0 set and bit 21 clear, while idle, starts a frame. In the next cycle busy (bit 1) reads 1, `memReq` is high with `memAddr` equal to the base, and progress (offset 0x10) reads 0.
- R5: Line n is requested at base + n × pitch, with `memLen` equal to the programmed width. A request holds its address until it is acknowledged, and the next line is requested in the cycle after the acknowledge.
- R6: Progress rises by one on every acknowledged line.
- R7: In the cycle after the last line's acknowledge, `memReq` is low and busy reads 0.
- R8: When control bit 2 is set, `irq` rises as the block becomes idle. It stays high until a control write clears bit 2. With bit 2 clear, the end of a frame leaves `irq` low.
- R9: A control write with bit 14 set during a frame ends it in the next cycle: busy reads 0, `memReq` stays low from then on, progress keeps its value, and `irq` rises if enabled.
- R10: A control write with bit 21 set stores the power-down bit and starts no frame, even when bit 0 is also set.
- R11: Starting with height 0 keeps the block idle, resets progress to 0, and raises `irq` in the next cycle if bit 2 is written set.
- R12: A start write during a frame is ignored: the current line request and the progress value are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for `regAddr` (combinational) |
| memReq | output | 1 | Line write request |
| memAddr | output | AddrW | Line start address |
| memLen | output | 16 | Line width in pixels |
| memAck | input | 1 | Line committed; sampled while `memReq` is high |
| irq | output | 1 | Idle interrupt (level) |

## Verification
Register writes take effect at the first clock edge after the strobe. The bench writes on a falling edge and reads the register port and the memory outputs on the next falling edge, one cycle after the write, so status, request and interrupt are all checked at the first cycle they can have changed. Acknowledges are driven on falling edges with a chosen gap. The memory responder compares each acknowledged request with a queue of expected line addresses, filled before each frame starts. Abort, restart and the zero-height start are sampled in the single cycle after the control write, and the abort test keeps sampling for several more cycles to confirm that no request comes back.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  localparam int RegAw = 5;
  localparam int RegDw = 32;
  localparam int DimW  = 16;

  localparam logic [RegAw-1:0] OffBase  = 5'h00;
  localparam logic [RegAw-1:0] OffPitch = 5'h04;
  localparam logic [RegAw-1:0] OffDim   = 5'h08;
  localparam logic [RegAw-1:0] OffCtrl  = 5'h0C;
  localparam logic [RegAw-1:0] OffProg  = 5'h10;

  localparam int BitGo    = 0;
  localparam int BitIrqEn = 2;
  localparam int BitAbort = 14;
  localparam int BitPwrDn = 21;

  localparam logic [7:0] IdTag = 8'h54;
  localparam logic [1:0] IdRev = 2'b01;

  typedef enum logic {SeqIdle, SeqActive} seqState_t;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic frameStart;   // load line address, clear progress
    logic lineAdvance;  // line committed: step address and progress
    logic frameEnd;     // block goes idle
  } seqStrobe_t;
endpackage

// File: rtl/fcs_datapath.sv
`timescale 1ns/1ps
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int MaxHeight = 4088
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [RegAw-1:0] regAddr,
  input  logic [RegDw-1:0] wrData,
  input  seqStrobe_t       strobes,
  input  logic             busy,
  output logic [RegDw-1:0] rdData,
  output logic             goReq,
  output logic             abortReq,
  output logic             lastLine,
  output logic             heightZero,
  output logic [AddrW-1:0] lineAddr,
  output logic [AddrW-1:0] pitchVal,
  output logic [DimW-1:0]  widthVal,
  output logic [DimW-1:0]  progressVal,
  output logic             irq
);
  localparam logic [DimW-1:0] HeightCap = DimW'(MaxHeight);

  logic [AddrW-1:0] baseReg, pitchReg, curAddr;
  logic [DimW-1:0]  widthReg, heightReg, progReg;
  logic             irqEnReg, pwrDnReg, irqFlag;
  logic             ctrlWr;
  logic [DimW-1:0]  heightIn;

  assign ctrlWr   = wrEn && (regAddr == OffCtrl);
  assign goReq    = ctrlWr && wrData[BitGo] && !wrData[BitPwrDn];
  assign abortReq = ctrlWr && wrData[BitAbort];
  assign heightIn = wrData[31:16];

  assign heightZero  = (heightReg == '0);
  assign lastLine    = (DimW'(progReg + 1'b1) == heightReg);
  assign lineAddr    = curAddr;
  assign pitchVal    = pitchReg;
  assign widthVal    = widthReg;
  assign progressVal = progReg;
  assign irq         = irqFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      pitchReg  <= '0;
      widthReg  <= '0;
      heightReg <= '0;
      irqEnReg  <= 1'b0;
      pwrDnReg  <= 1'b0;
      curAddr   <= '0;
      progReg   <= '0;
      irqFlag   <= 1'b0;
    end else begin
      if (wrEn) begin
        case (regAddr)
          OffBase:  baseReg  <= {wrData[AddrW-1:2], 2'b00};
          OffPitch: pitchReg <= {wrData[AddrW-1:4], 4'h0};
          OffDim: begin
            widthReg  <= wrData[15:0];
            heightReg <= (heightIn > HeightCap) ? HeightCap : heightIn;
          end
          OffCtrl: begin
            irqEnReg <= wrData[BitIrqEn];
            pwrDnReg <= wrData[BitPwrDn];
          end
          default: ;
        endcase
      end
      if (strobes.frameStart) begin
        curAddr <= baseReg;
        progReg <= '0;
      end else if (strobes.lineAdvance) begin
        curAddr <= curAddr + pitchReg;
        progReg <= progReg + 1'b1;
      end
      // A clearing write wins over a frame end in the same cycle
      if (ctrlWr && !wrData[BitIrqEn]) irqFlag <= 1'b0;
      else if (strobes.frameEnd && (ctrlWr ? wrData[BitIrqEn] : irqEnReg)) irqFlag <= 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      OffBase:  rdData = RegDw'(baseReg);
      OffPitch: rdData = RegDw'(pitchReg);
      OffDim:   rdData = {heightReg, widthReg};
      OffCtrl:  rdData = {IdTag, IdRev, pwrDnReg, 18'b0, irqEnReg, busy, 1'b0};
      OffProg:  rdData = RegDw'(progReg);
      default:  rdData = '0;
    endcase
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !(ctrlWr && !wrData[BitIrqEn]) |=> irqFlag); // R8
endmodule

// File: rtl/fcs_ctrl.sv
`timescale 1ns/1ps
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goReq,
  input  logic       abortReq,
  input  logic       memAck,
  input  logic       lastLine,
  input  logic       heightZero,
  output seqStrobe_t strobes,
  output logic       busy,
  output logic       memReq
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      SeqIdle: begin
        if (goReq) begin
          strobes.frameStart = 1'b1;
          if (heightZero) strobes.frameEnd = 1'b1;
          else            stateNext = SeqActive;
        end
      end
      SeqActive: begin
        if (abortReq) begin
          strobes.frameEnd = 1'b1;
          stateNext = SeqIdle;
        end else if (memAck) begin
          strobes.lineAdvance = 1'b1;
          if (lastLine) begin
            strobes.frameEnd = 1'b1;
            stateNext = SeqIdle;
          end
        end
      end
      default: stateNext = SeqIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SeqIdle;
    else       state <= stateNext;
  end

  assign busy   = (state == SeqActive);
  assign memReq = busy;

  AST_ZERO_HEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !busy && goReq && heightZero |=> !busy); // R11
endmodule

// File: rtl/frame_capture_seq.sv
`timescale 1ns/1ps
module frame_capture_seq
  import fcs_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int MaxHeight = 4088
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [4:0]       regAddr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             memReq,
  output logic [AddrW-1:0] memAddr,
  output logic [15:0]      memLen,
  input  logic             memAck,
  output logic             irq
);
  seqStrobe_t       strobes;
  logic             busy, goReq, abortReq, lastLine, heightZero;
  logic [AddrW-1:0] pitchVal;
  logic [DimW-1:0]  progressVal;

  fcs_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .goReq      (goReq),
    .abortReq   (abortReq),
    .memAck     (memAck),
    .lastLine   (lastLine),
    .heightZero (heightZero),
    .strobes    (strobes),
    .busy       (busy),
    .memReq     (memReq)
  );

  fcs_datapath #(.AddrW(AddrW), .MaxHeight(MaxHeight)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .regAddr     (regAddr),
    .wrData      (wrData),
    .strobes     (strobes),
    .busy        (busy),
    .rdData      (rdData),
    .goReq       (goReq),
    .abortReq    (abortReq),
    .lastLine    (lastLine),
    .heightZero  (heightZero),
    .lineAddr    (memAddr),
    .pitchVal    (pitchVal),
    .widthVal    (memLen),
    .progressVal (progressVal),
    .irq         (irq)
  );

  logic ctrlWrite, abortWrite;
  assign ctrlWrite  = wrEn && (regAddr == OffCtrl);
  assign abortWrite = ctrlWrite && wrData[BitAbort];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !abortWrite |=> memReq && $stable(memAddr)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !lastLine && !abortWrite |=>
      memReq && (memAddr == $past(memAddr) + $past(pitchVal))); // R5
  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !abortWrite |=> progressVal == $past(progressVal) + 16'd1); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && lastLine && !abortWrite |=> !memReq); // R7
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && abortWrite |=> !memReq && !busy); // R9
  AST_PD_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !busy && ctrlWrite && wrData[BitPwrDn] |=> !busy); // R10
endmodule

// File: tb/frame_capture_seq_test.sv
`timescale 1ns/1ps
module frame_capture_seq_test;
  localparam int ClkPeriod = 10;
  localparam logic [4:0] ABase = 5'h00, APitch = 5'h04, ADim = 5'h08,
                         ACtrl = 5'h0C, AProg = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        memReq;
  logic [31:0] memAddr;
  logic [15:0] memLen;
  logic        memAck = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  logic [15:0] expLen = '0;
  bit  ackEn = 1'b0;
  int  ackGap = 0;
  int  ackCnt = 0;

  frame_capture_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .memReq(memReq), .memAddr(memAddr), .memLen(memLen),
    .memAck(memAck), .irq(irq)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      regRead(ACtrl, v);
      if (!v[1]) break;
    end
  endtask

  // Monitor / memory responder: pops expected line addresses on each acknowledge
  initial begin
    logic [31:0] e;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq && ackEn) begin
        if (ackCnt >= ackGap) begin
          ackCnt = 0;
          if (expQ.size() == 0) chk("R5 unexpected request", memAddr, 32'hDEAD_BEEF);
          else begin
            e = expQ.pop_front();
            chk("R5 line address", memAddr, e);
            chk("R5 line length", {16'h0, memLen}, {16'h0, expLen});
          end
          memAck = 1'b1;
        end else ackCnt++;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++; checks++;
    $display("FAIL watchdog R1-wide run actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(ACtrl, v); chk("R1 ctrl reset", v, 32'h5440_0000);
    regRead(ABase, v); chk("R1 base reset", v, 0);
    regRead(ADim, v);  chk("R1 dim reset", v, 0);
    regRead(AProg, v); chk("R1 progress reset", v, 0);
    chk("R1 irq/memReq reset", {30'b0, irq, memReq}, 0);

    // R2 / R10: all-ones write keeps ID bits, powers down, starts nothing
    regWrite(ACtrl, 32'hFFFF_FFFF);
    regRead(ACtrl, v); chk("R2 R10 ctrl readback", v, 32'h5460_0004);
    chk("R10 no request", {31'b0, memReq}, 0);
    chk("R2 no irq while idle", {31'b0, irq}, 0);
    regWrite(ACtrl, 32'h0);
    regRead(ACtrl, v); chk("R2 ctrl cleared", v, 32'h5440_0000);

    // R3 alignment and height cap
    regWrite(ABase, 32'h0000_1003);
    regRead(ABase, v); chk("R3 base align", v, 32'h0000_1000);
    regWrite(APitch, 32'h0000_004F);
    regRead(APitch, v); chk("R3 pitch align", v, 32'h0000_0040);
    regWrite(ADim, {16'd5000, 16'd640});
    regRead(ADim, v); chk("R3 height cap", v, {16'd4088, 16'd640});

    // R4-R8 normal frame, interrupt enabled
    regWrite(ADim, {16'd3, 16'd320});
    expLen = 16'd320;
    expQ.push_back(32'h1000); expQ.push_back(32'h1040); expQ.push_back(32'h1080);
    ackGap = 1; ackCnt = 0; ackEn = 1'b1;
    regWrite(ACtrl, 32'h0000_0005);
    regRead(ACtrl, v); chk("R4 busy after start", v, 32'h5440_0006);
    chk("R4 first request", memReq ? memAddr : 32'hFFFF_FFFF, 32'h1000);
    regRead(AProg, v); chk("R4 progress cleared", v, 0);
    waitIdle();
    chk("R7 request dropped", {31'b0, memReq}, 0);
    chk("R5 all lines requested", expQ.size(), 0);
    regRead(AProg, v); chk("R6 progress count", v, 3);
    chk("R8 irq on idle", {31'b0, irq}, 1);
    regWrite(ABase, 32'h0000_2000);
    chk("R8 irq held", {31'b0, irq}, 1);
    regWrite(ACtrl, 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 0);

    // R8 negative: interrupt disabled, zero ack gap
    regWrite(ADim, {16'd2, 16'd64});
    expLen = 16'd64;
    expQ.push_back(32'h2000); expQ.push_back(32'h2040);
    ackGap = 0; ackCnt = 0;
    regWrite(ACtrl, 32'h0000_0001);
    waitIdle();
    regRead(AProg, v); chk("R6 progress two lines", v, 2);
    chk("R8 no irq when disabled", {31'b0, irq}, 0);

    // R12 restart ignored, then R9 abort
    regWrite(ABase, 32'h0000_3000);
    regWrite(APitch, 32'h0000_0100);
    regWrite(ADim, {16'd4, 16'd100});
    expLen = 16'd100;
    for (int i = 0; i < 4; i++) expQ.push_back(32'h3000 + 32'(i) * 32'h100);
    ackGap = 3; ackCnt = 0;
    regWrite(ACtrl, 32'h0000_0005);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      regRead(AProg, v);
      if (v == 2) break;
    end
    ackEn = 1'b0;
    regWrite(ACtrl, 32'h0000_0005);
    regRead(AProg, v); chk("R12 progress kept", v, 2);
    chk("R12 request kept", memReq ? memAddr : 32'hFFFF_FFFF, 32'h3200);
    regWrite(ACtrl, 32'h0000_4004);
    regRead(ACtrl, v); chk("R9 idle after abort", v, 32'h5440_0004);
    regRead(AProg, v); chk("R9 progress frozen", v, 2);
    chk("R9 irq after abort", {31'b0, irq}, 1);
    expQ.delete();
    ackEn = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 no further requests", {31'b0, memReq}, 0);
    regWrite(ACtrl, 32'h0);

    // R11 zero height
    regWrite(ADim, {16'd0, 16'd100});
    regWrite(ACtrl, 32'h0000_0005);
    regRead(ACtrl, v); chk("R11 stays idle", v, 32'h5440_0004);
    chk("R11 irq raised", {30'b0, irq, memReq}, 32'h2);
    regRead(AProg, v); chk("R11 progress zero", v, 0);
    regWrite(ACtrl, 32'h0);

    // R10 start together with power-down
    regWrite(ADim, {16'd3, 16'd100});
    regWrite(AProg, 32'h0);
    regWrite(ACtrl, 32'h0020_0001);
    regRead(ACtrl, v); chk("R10 powered down idle", v, 32'h5460_0000);
    repeat (3) @(negedge clk);
    chk("R10 no request", {31'b0, memReq}, 0);
    regWrite(ACtrl, 32'h0);

    summary();
    $finish;
  end
endmodule